// File: doc/BRIEF.md
# Phase-Frequency Detector With Pump Control

This block compares two single-cycle strobes, one from the reference divider and one from the feedback divider, both synchronous to the system clock. Whichever strobe arrives first opens a pump request in its direction. When the other strobe arrives, both requests are asserted together for a programmable minimum width, which removes the dead zone around lock. Up, down and output-enable drive an external charge pump. Polarity, forced pump-off and a test routing mode reshape those outputs.

A second state machine decodes chip enable and the two power-control bits. Counter reset and power down each raise a hold request to both dividers. The asynchronous forms take effect in the same cycle. The synchronous form first lets the pump pulse in progress finish.

Detector states: `PFD_IDLE`, `PFD_LEAD_REF`, `PFD_LEAD_FB`, `PFD_ALIGN`.
- Idle goes to lead-ref on a reference strobe alone, to lead-fb on a feedback strobe alone, and to align when both strobes arrive together.
- Lead-ref goes to align on a feedback strobe. Lead-fb goes to align on a reference strobe.
- Align lasts MIN_PW cycles. On its last cycle it goes to align, lead-ref, lead-fb or idle according to the strobes seen during the window.
- The clear input returns any state to idle.

Mode states: `MODE_RUN`, `MODE_SYNC_WAIT`, `MODE_CNT_RST`, `MODE_PDN`.
- Run goes to sync-wait on a synchronous request while the detector is busy, or straight to powered-down if the detector is idle.
- Sync-wait goes to powered-down once the detector is idle.
- Any state goes to powered-down on an asynchronous request, and to counter-reset on a reset request.
- Any state returns to run when the bits read 00 with chip enable high.

Top module: `pfd_pump_ctrl`

## Requirements
- R1: After reset, with chip enable high and both power bits 0, up, down, output-enable, test output and hold are all 0.
- R2: With polarity 1, a reference strobe that leads the feedback strobe asserts up from the cycle after the reference strobe until MIN_PW cycles after the feedback strobe. Down is asserted for exactly MIN_PW cycles, starting the cycle after the feedback strobe.
- R3: With polarity 1 and the feedback strobe leading, the roles of R2 are mirrored: down is held long and up is the MIN_PW-cycle pulse.
- R4: Strobes that arrive in the same cycle assert up and down together for exactly MIN_PW cycles. Output-enable is 1 exactly when up or down is 1, so the output is high-impedance while the detector is idle.
- R5: Polarity 0 exchanges the up and down outputs; the change takes effect in the same cycle.
- R6: Repeated reference strobes with no feedback strobe keep up asserted without a gap (frequency discrimination). Random strobe patterns match a cycle model built from R2–R4.
- R7: Pump-off 1 with test routing 0 forces up, down and output-enable to 0 in the same cycle and clears the detector. After pump-off returns to 0, a lone feedback strobe produces down.
- R8: Test routing 1, which requires pump-off 1, sets up and down to 0 and output-enable to 1. The test output follows the reference strobe when polarity is 0 and the feedback strobe when polarity is 1, in the same cycle.
- R9: With chip enable high, bits (counter reset, power down) = 10 raise hold from the next cycle and keep the pump idle. Strobes received meanwhile are ignored.
- R10: Bits 01 request synchronous power down. If no pump pulse is active, hold rises one cycle later. Otherwise hold stays 0 and the pulse runs to completion. Hold then rises the cycle after the pump outputs fall, and no new comparison starts in the meantime.
- R11: Chip enable 0, or bits 11, force hold to 1 and up, down and output-enable to 0 in the same cycle, whatever the other control inputs are.
- R12: Returning to bits 00 with chip enable high drops hold after one clock edge. The detector then starts from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse_i | input | 1 | Reference divider strobe, one cycle wide |
| fb_pulse_i | input | 1 | Feedback divider strobe, one cycle wide |
| polarity_i | input | 1 | 1: reference leading pumps up; 0: swapped |
| pump_off_i | input | 1 | Force pump and detector to high impedance |
| test_route_i | input | 1 | Route a divider strobe to test_o |
| cnt_reset_i | input | 1 | Counter-reset control bit |
| pwr_down_i | input | 1 | Power-down control bit |
| chip_en_i | input | 1 | Chip enable; 0 powers down at once |
| pump_up_o | output | 1 | Charge pump source request |
| pump_dn_o | output | 1 | Charge pump sink request |
| pump_oe_o | output | 1 | Pump output driven (0 = high impedance) |
| test_o | output | 1 | Routed divider strobe in test mode |
| div_hold_o | output | 1 | Hold both dividers at their load point |

## Verification
The assertions check the following on every cycle:
- simultaneous strobes lead to both requests;
- a lead state persists until the opposing strobe arrives;
- an asynchronous request always lands in the powered-down state;
- a busy synchronous request parks in sync-wait;
- chip enable low silences the pump and raises hold.

The bench scenarios show the rest:
- the exact pulse widths;
- polarity swapping;
- the completion-gated entry into synchronous power down;
- the discard of stale detector state after pump-off, counter reset or power down;
- agreement with a cycle model under random strobe patterns.

// File: rtl/pfd_pump_pkg.sv
package pfd_pump_pkg;

    typedef enum logic [1:0] {
        PFD_IDLE     = 2'd0,
        PFD_LEAD_REF = 2'd1,
        PFD_LEAD_FB  = 2'd2,
        PFD_ALIGN    = 2'd3
    } pfd_state_e;

    typedef enum logic [1:0] {
        MODE_RUN       = 2'd0,
        MODE_SYNC_WAIT = 2'd1,
        MODE_CNT_RST   = 2'd2,
        MODE_PDN       = 2'd3
    } mode_state_e;

endpackage

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pump_pkg::*;
#(
    parameter int MIN_PW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic no_start_i,
    input  logic ref_i,
    input  logic fb_i,
    output logic raw_up_o,
    output logic raw_dn_o,
    output logic busy_o
);

    localparam int CNT_W = (MIN_PW > 1) ? $clog2(MIN_PW) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(MIN_PW - 1);

    pfd_state_e       st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             pend_r, pend_r_nx;
    logic             pend_f, pend_f_nx;
    logic             any_r, any_f;

    assign any_r = pend_r | ref_i;
    assign any_f = pend_f | fb_i;

    always_comb begin
        st_nx     = st;
        cnt_nx    = cnt;
        pend_r_nx = pend_r;
        pend_f_nx = pend_f;
        if (clr_i) begin
            st_nx     = PFD_IDLE;
            cnt_nx    = '0;
            pend_r_nx = 1'b0;
            pend_f_nx = 1'b0;
        end else begin
            unique case (st)
                PFD_IDLE: begin
                    if (!no_start_i) begin
                        if (ref_i && fb_i) begin
                            st_nx  = PFD_ALIGN;
                            cnt_nx = CNT_LOAD;
                        end else if (ref_i) begin
                            st_nx = PFD_LEAD_REF;
                        end else if (fb_i) begin
                            st_nx = PFD_LEAD_FB;
                        end
                    end
                end
                PFD_LEAD_REF: begin
                    if (fb_i) begin
                        st_nx  = PFD_ALIGN;
                        cnt_nx = CNT_LOAD;
                    end
                end
                PFD_LEAD_FB: begin
                    if (ref_i) begin
                        st_nx  = PFD_ALIGN;
                        cnt_nx = CNT_LOAD;
                    end
                end
                PFD_ALIGN: begin
                    if (cnt != '0) begin
                        cnt_nx    = cnt - 1'b1;
                        pend_r_nx = any_r;
                        pend_f_nx = any_f;
                    end else begin
                        pend_r_nx = 1'b0;
                        pend_f_nx = 1'b0;
                        if (no_start_i) begin
                            st_nx = PFD_IDLE;
                        end else if (any_r && any_f) begin
                            st_nx  = PFD_ALIGN;
                            cnt_nx = CNT_LOAD;
                        end else if (any_r) begin
                            st_nx = PFD_LEAD_REF;
                        end else if (any_f) begin
                            st_nx = PFD_LEAD_FB;
                        end else begin
                            st_nx = PFD_IDLE;
                        end
                    end
                end
                default: st_nx = PFD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= PFD_IDLE;
            cnt    <= '0;
            pend_r <= 1'b0;
            pend_f <= 1'b0;
        end else begin
            st     <= st_nx;
            cnt    <= cnt_nx;
            pend_r <= pend_r_nx;
            pend_f <= pend_f_nx;
        end
    end

    always_comb begin
        raw_up_o = 1'b0;
        raw_dn_o = 1'b0;
        unique case (st)
            PFD_IDLE:     ;
            PFD_LEAD_REF: raw_up_o = 1'b1;
            PFD_LEAD_FB:  raw_dn_o = 1'b1;
            PFD_ALIGN: begin
                raw_up_o = 1'b1;
                raw_dn_o = 1'b1;
            end
            default: ;
        endcase
        busy_o = (st != PFD_IDLE);
    end

    // R4
    both_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PFD_IDLE && ref_i && fb_i && !clr_i && !no_start_i) |=> (raw_up_o && raw_dn_o));

    // R6
    lead_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PFD_LEAD_REF && !fb_i && !clr_i) |=> (raw_up_o && !raw_dn_o));

endmodule

// File: rtl/pfd_mode_seq.sv
module pfd_mode_seq
    import pfd_pump_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chip_en_i,
    input  logic cnt_reset_i,
    input  logic pwr_down_i,
    input  logic busy_i,
    output logic allow_o,
    output logic no_start_o,
    output logic hold_o
);

    mode_state_e st, st_nx;
    logic async_req, sync_req, rst_req;

    assign async_req = !chip_en_i || (cnt_reset_i && pwr_down_i);
    assign sync_req  = chip_en_i && !cnt_reset_i && pwr_down_i;
    assign rst_req   = chip_en_i && cnt_reset_i && !pwr_down_i;

    always_comb begin
        st_nx = st;
        if (async_req) begin
            st_nx = MODE_PDN;
        end else if (rst_req) begin
            st_nx = MODE_CNT_RST;
        end else if (sync_req) begin
            unique case (st)
                MODE_RUN:       st_nx = busy_i ? MODE_SYNC_WAIT : MODE_PDN;
                MODE_SYNC_WAIT: st_nx = busy_i ? MODE_SYNC_WAIT : MODE_PDN;
                MODE_CNT_RST:   st_nx = MODE_PDN;
                MODE_PDN:       st_nx = MODE_PDN;
                default:        st_nx = MODE_PDN;
            endcase
        end else begin
            st_nx = MODE_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= MODE_RUN;
        else        st <= st_nx;
    end

    always_comb begin
        allow_o    = 1'b0;
        no_start_o = sync_req;
        hold_o     = async_req;
        unique case (st)
            MODE_RUN:       allow_o = !async_req;
            MODE_SYNC_WAIT: begin
                allow_o    = !async_req;
                no_start_o = 1'b1;
            end
            MODE_CNT_RST:   hold_o = 1'b1;
            MODE_PDN:       hold_o = 1'b1;
            default:        hold_o = 1'b1;
        endcase
    end

    // R11
    async_pdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        async_req |=> (st == MODE_PDN));

    // R10
    sync_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == MODE_RUN && sync_req && busy_i) |=> (st == MODE_SYNC_WAIT));

endmodule

// File: rtl/pfd_out_stage.sv
module pfd_out_stage (
    input  logic allow_i,
    input  logic raw_up_i,
    input  logic raw_dn_i,
    input  logic polarity_i,
    input  logic pump_off_i,
    input  logic test_route_i,
    input  logic ref_i,
    input  logic fb_i,
    output logic up_o,
    output logic dn_o,
    output logic oe_o,
    output logic test_o
);

    always_comb begin
        up_o   = 1'b0;
        dn_o   = 1'b0;
        oe_o   = 1'b0;
        test_o = 1'b0;
        if (allow_i) begin
            if (test_route_i) begin
                oe_o   = 1'b1;
                test_o = polarity_i ? fb_i : ref_i;
            end else if (!pump_off_i) begin
                up_o = polarity_i ? raw_up_i : raw_dn_i;
                dn_o = polarity_i ? raw_dn_i : raw_up_i;
                oe_o = raw_up_i | raw_dn_i;
            end
        end
    end

endmodule

// File: rtl/pfd_pump_ctrl.sv
module pfd_pump_ctrl #(
    parameter int MIN_PW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pulse_i,
    input  logic fb_pulse_i,
    input  logic polarity_i,
    input  logic pump_off_i,
    input  logic test_route_i,
    input  logic cnt_reset_i,
    input  logic pwr_down_i,
    input  logic chip_en_i,
    output logic pump_up_o,
    output logic pump_dn_o,
    output logic pump_oe_o,
    output logic test_o,
    output logic div_hold_o
);

    logic allow, no_start, busy, raw_up, raw_dn, pfd_clr;

    assign pfd_clr = !allow || pump_off_i || test_route_i;

    pfd_mode_seq i_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_en_i  (chip_en_i),
        .cnt_reset_i(cnt_reset_i),
        .pwr_down_i (pwr_down_i),
        .busy_i     (busy),
        .allow_o    (allow),
        .no_start_o (no_start),
        .hold_o     (div_hold_o)
    );

    pfd_core #(.MIN_PW(MIN_PW)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (pfd_clr),
        .no_start_i(no_start),
        .ref_i     (ref_pulse_i),
        .fb_i      (fb_pulse_i),
        .raw_up_o  (raw_up),
        .raw_dn_o  (raw_dn),
        .busy_o    (busy)
    );

    pfd_out_stage i_out (
        .allow_i     (allow),
        .raw_up_i    (raw_up),
        .raw_dn_i    (raw_dn),
        .polarity_i  (polarity_i),
        .pump_off_i  (pump_off_i),
        .test_route_i(test_route_i),
        .ref_i       (ref_pulse_i),
        .fb_i        (fb_pulse_i),
        .up_o        (pump_up_o),
        .dn_o        (pump_dn_o),
        .oe_o        (pump_oe_o),
        .test_o      (test_o)
    );

    // R11
    ce_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en_i |-> (!pump_up_o && !pump_dn_o && !pump_oe_o && div_hold_o));

    // R8
    test_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en_i && !pwr_down_i && !cnt_reset_i && test_route_i) |-> (!pump_up_o && !pump_dn_o));

endmodule

// File: tb/test_pfd_pump_ctrl.sv
module test_pfd_pump_ctrl;

    localparam int MIN_PW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_p = 1'b0, fb_p = 1'b0;
    logic pol = 1'b1, poff = 1'b0, troute = 1'b0;
    logic crst = 1'b0, pdn = 1'b0, ce = 1'b1;
    logic up, dn, oe, tout, hold;

    int checks = 0;
    int errors = 0;

    // cycle model state
    logic m_up_lead = 1'b0, m_dn_lead = 1'b0;
    logic m_pr = 1'b0, m_pf = 1'b0;
    int   m_al = 0;

    always #5 clk = ~clk;

    pfd_pump_ctrl #(.MIN_PW(MIN_PW)) i_pfd_pump_ctrl (
        .clk(clk), .rst_n(rst_n), .ref_pulse_i(ref_p), .fb_pulse_i(fb_p),
        .polarity_i(pol), .pump_off_i(poff), .test_route_i(troute),
        .cnt_reset_i(crst), .pwr_down_i(pdn), .chip_en_i(ce),
        .pump_up_o(up), .pump_dn_o(dn), .pump_oe_o(oe), .test_o(tout),
        .div_hold_o(hold)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        m_up_lead = 1'b0; m_dn_lead = 1'b0; m_pr = 1'b0; m_pf = 1'b0; m_al = 0;
    endtask

    task automatic model_step(input logic r, input logic f);
        logic pr, pf;
        if (m_al > 0) begin
            if (m_al > 1) begin
                m_al--; m_pr |= r; m_pf |= f;
            end else begin
                pr = m_pr | r; pf = m_pf | f;
                m_pr = 1'b0; m_pf = 1'b0; m_al = 0;
                if (pr && pf) m_al = MIN_PW;
                else if (pr)  m_up_lead = 1'b1;
                else if (pf)  m_dn_lead = 1'b1;
            end
        end else if (m_up_lead) begin
            if (f) begin m_up_lead = 1'b0; m_al = MIN_PW; end
        end else if (m_dn_lead) begin
            if (r) begin m_dn_lead = 1'b0; m_al = MIN_PW; end
        end else begin
            if (r && f)  m_al = MIN_PW;
            else if (r)  m_up_lead = 1'b1;
            else if (f)  m_dn_lead = 1'b1;
        end
    endtask

    function automatic logic exp_up(input logic p);
        logic ru = m_up_lead || (m_al > 0);
        logic rd = m_dn_lead || (m_al > 0);
        return p ? ru : rd;
    endfunction

    function automatic logic exp_dn(input logic p);
        logic ru = m_up_lead || (m_al > 0);
        logic rd = m_dn_lead || (m_al > 0);
        return p ? rd : ru;
    endfunction

    function automatic logic exp_oe();
        return m_up_lead || m_dn_lead || (m_al > 0);
    endfunction

    // drive at a falling edge, let one rising edge consume, return at next falling edge
    task automatic tick(input logic r, input logic f);
        ref_p = r; fb_p = f;
        @(negedge clk);
        ref_p = 1'b0; fb_p = 1'b0;
        model_step(r, f);
    endtask

    task automatic cmp(input string tag);
        chk({tag, " up"}, up, exp_up(pol));
        chk({tag, " dn"}, dn, exp_dn(pol));
        chk({tag, " oe"}, oe, exp_oe());
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 up", up, 1'b0); chk("R1 dn", dn, 1'b0); chk("R1 oe", oe, 1'b0);
        chk("R1 test", tout, 1'b0); chk("R1 hold", hold, 1'b0);

        // R2 reference leads, polarity 1
        pol = 1'b1;
        tick(1, 0); cmp("R2 lead");
        tick(0, 0); cmp("R2 lead");
        tick(0, 1); cmp("R2 align");
        chk("R2 dn start", dn, 1'b1);
        tick(0, 0); cmp("R2 align2");
        tick(0, 0); cmp("R2 end");
        chk("R2 up off", up, 1'b0);

        // R3 feedback leads
        tick(0, 1); cmp("R3 lead");
        chk("R3 dn on", dn, 1'b1); chk("R3 up off", up, 1'b0);
        tick(1, 0); cmp("R3 align");
        tick(0, 0); cmp("R3 align2");
        tick(0, 0); cmp("R3 end");

        // R4 aligned strobes: both for MIN_PW cycles, then high impedance
        tick(1, 1); cmp("R4 a");
        chk("R4 both", up & dn, 1'b1);
        tick(0, 0); cmp("R4 b");
        tick(0, 0); cmp("R4 idle");
        chk("R4 oe idle", oe, 1'b0);

        // R5 polarity 0 swaps
        pol = 1'b0;
        tick(1, 0); cmp("R5 swap");
        chk("R5 dn on", dn, 1'b1);
        pol = 1'b1; #1;
        chk("R5 live up", up, 1'b1);
        tick(0, 1); tick(0, 0); tick(0, 0); cmp("R5 idle");

        // R6 repeated reference strobes keep up asserted
        tick(1, 0); cmp("R6 f1");
        tick(1, 0); cmp("R6 f2");
        tick(1, 0); cmp("R6 f3");
        chk("R6 up held", up, 1'b1);
        tick(0, 1); tick(0, 0); tick(0, 0); cmp("R6 idle");

        // R7 forced pump-off clears the detector
        tick(1, 0);
        poff = 1'b1; #1;
        chk("R7 up", up, 1'b0); chk("R7 dn", dn, 1'b0); chk("R7 oe", oe, 1'b0);
        @(negedge clk);
        poff = 1'b0;
        model_clear();
        tick(0, 1); cmp("R7 fresh");
        chk("R7 up after", up, 1'b0);
        tick(1, 0); tick(0, 0); tick(0, 0);

        // R8 test routing
        poff = 1'b1; troute = 1'b1; pol = 1'b0;
        ref_p = 1'b1; #1;
        chk("R8 ref route", tout, 1'b1); chk("R8 up", up, 1'b0);
        chk("R8 dn", dn, 1'b0); chk("R8 oe", oe, 1'b1);
        ref_p = 1'b0; fb_p = 1'b1; #1;
        chk("R8 fb blocked", tout, 1'b0);
        pol = 1'b1; #1;
        chk("R8 fb route", tout, 1'b1);
        fb_p = 1'b0; ref_p = 1'b1; #1;
        chk("R8 ref blocked", tout, 1'b0);
        ref_p = 1'b0;
        @(negedge clk);
        troute = 1'b0; poff = 1'b0;
        model_clear();

        // R9 counter reset
        crst = 1'b1; #1;
        chk("R9 not yet", hold, 1'b0);
        @(negedge clk);
        chk("R9 hold", hold, 1'b1);
        ref_p = 1'b1; @(negedge clk); ref_p = 1'b0;
        chk("R9 up", up, 1'b0); chk("R9 oe", oe, 1'b0);
        // R12 release
        crst = 1'b0;
        @(negedge clk);
        chk("R12 hold drop", hold, 1'b0);
        model_clear();
        tick(0, 1); cmp("R12 fresh");
        chk("R12 dn", dn, 1'b1);
        tick(1, 0); tick(0, 0); tick(0, 0);

        // R10 synchronous power down, idle case
        pdn = 1'b1; #1;
        chk("R10 idle wait", hold, 1'b0);
        @(negedge clk);
        chk("R10 idle hold", hold, 1'b1);
        pdn = 1'b0; @(negedge clk);
        chk("R12 hold drop2", hold, 1'b0);

        // R10 synchronous power down during a pulse
        model_clear();
        tick(1, 0);
        pdn = 1'b1;
        tick(0, 0); cmp("R10 pulse runs"); chk("R10 h1", hold, 1'b0);
        tick(0, 1); cmp("R10 align");      chk("R10 h2", hold, 1'b0);
        tick(0, 0); cmp("R10 align2");     chk("R10 h3", hold, 1'b0);
        tick(1, 0); chk("R10 no start up", up, 1'b0); chk("R10 h4", hold, 1'b0);
        @(negedge clk);
        chk("R10 hold", hold, 1'b1);
        pdn = 1'b0; @(negedge clk);
        model_clear();

        // R11 chip enable low and bits 11
        tick(1, 0); chk("R11 pre up", up, 1'b1);
        ce = 1'b0; #1;
        chk("R11 ce up", up, 1'b0); chk("R11 ce oe", oe, 1'b0); chk("R11 ce hold", hold, 1'b1);
        @(negedge clk);
        ce = 1'b1; @(negedge clk);
        chk("R12 ce back", hold, 1'b0);
        model_clear();
        tick(0, 1); chk("R11 fresh dn", dn, 1'b1);
        crst = 1'b1; pdn = 1'b1; #1;
        chk("R11 bits dn", dn, 1'b0); chk("R11 bits hold", hold, 1'b1);
        @(negedge clk);
        crst = 1'b0; pdn = 1'b0; @(negedge clk);
        model_clear();

        // R6 random strobe patterns against the cycle model
        for (int i = 0; i < 3000; i++) begin
            if (i % 500 == 499) pol = ~pol;
            tick(($urandom % 7) == 0, ($urandom % 7) == 0);
            cmp("R6 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule